// File: doc/BRIEF.md
# Data Access Translation and Protection Checker

This block sits between a load/store unit and the memory system. For each data access it decides, in one registered step, whether the access may proceed and where it goes. It returns either a physical address with a cacheability mark, or a fault code with a memory-management status word that software can use to find out why the access was refused. It does not hold any translation entries. The lookup result (hit, page number, per-mode read and write enable masks, fault-on-read and fault-on-write bits) comes from an external translation buffer in the same cycle as the request.

The checks run in a fixed priority order:

1. Alignment.
2. Physical-mode bypass.
3. Virtual address validity.
4. A kernel-only direct-mapped window.
5. Translation miss.
6. Per-mode permissions and the fault-on bits.
7. The implemented physical range.
8. The uncached region.

The result appears on the response ports one clock after the request is presented.

Modes are encoded kernel=0, executive=1, supervisor=2, user=3. Bit i of an enable mask grants access in mode i. Fault codes are: none=0, alignment=1, page=2, access-violation=3, miss=4, double-miss=5, machine-check=6, unimplemented=7. Status bits are: [0] write, [1] access-violation, [2] fault-on-read, [3] fault-on-write, [4] bad-VA, [5] miss.

Top module: `dtx_xlate_chk`

## Requirements
- R1: While reset is held and after its release, before any request is accepted, the response ports are all zero.
- R2: The response appears exactly one cycle after the request cycle. A cycle with reqValid low produces rspValid low and zero fault, status, address and uncache mark. Any fault returns a zero physical address and no uncache mark.
- R3: An address that is not a multiple of 2^reqSizeLog2 bytes gives fault 1, whatever else is wrong with the access. The status is write-only for stores and zero for loads.
- R4: The permission masks are indexed by an effective mode. For a privileged-code request this is altMode if reqAlt is set and kernel otherwise. For any other request it is curMode.
- R5: A physical-mode request skips translation and permission checks and uses the virtual address unchanged as the physical address.
- R6: Outside physical mode, a virtual address whose bits 63:47 are not all equal gives fault 2. Its status is bad-VA and access-violation, plus write for stores.
- R7: A valid address with bits 47:41 equal to 0x7E is in the direct window. There it is allowed only when curMode is kernel, even for privileged-code requests. Otherwise it gives fault 3 with status access-violation, plus write for stores.
- R8: A direct-window physical address is the virtual address masked to 44 bits. If bit 40 is set, it is ORed with 0xF00_0000_0000. Otherwise it is cut to 40 bits.
- R9: A translation miss gives fault 4, or fault 5 when reqPteFetch is set. The status is miss, plus write for stores.
- R10: On a hit the physical address is the page number shifted left by 13, joined with virtual bits 12:0.
- R11: A store whose effective-mode bit is clear in the write mask gives fault 2 with status write, access-violation, plus fault-on-write if that bit is set. A permitted store with fault-on-write set gives fault 2 with status write and fault-on-write.
- R12: A load whose effective-mode bit is clear in the read mask gives fault 3 with status access-violation, plus fault-on-read if that bit is set. A permitted load with fault-on-read set gives fault 2 with status fault-on-read.
- R13: A physical address with any of bits 63:44 set gives fault 6 with zero status.
- R14: If physical bit 43 is set and bits 43:20 are all ones, the result is fault 7 with zero status. If bit 43 is set in any other case, the access is marked uncacheable and bits 42:35 of the returned address are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqVa | input | 64 | Virtual address |
| reqSizeLog2 | input | 2 | Access size as log2 of bytes |
| reqWrite | input | 1 | Store when 1, load when 0 |
| reqPhys | input | 1 | Physical-mode access |
| reqPriv | input | 1 | Request issued by privileged code |
| reqAlt | input | 1 | Use the alternate mode (privileged code only) |
| reqPteFetch | input | 1 | Access is a page-table-entry fetch |
| curMode | input | 2 | Current processor mode |
| altMode | input | 2 | Alternate mode value |
| tbHit | input | 1 | Translation buffer hit |
| tbPpn | input | 51 | Physical page number from the hit entry |
| tbReadEn | input | 4 | Per-mode read enable mask |
| tbWriteEn | input | 4 | Per-mode write enable mask |
| tbFaultOnRead | input | 1 | Fault-on-read bit of the entry |
| tbFaultOnWrite | input | 1 | Fault-on-write bit of the entry |
| rspValid | output | 1 | Response present |
| rspFault | output | 3 | Fault code |
| rspStatus | output | 6 | Memory-management status flags |
| rspPaddr | output | 64 | Physical address (zero on fault) |
| rspUncache | output | 1 | Access is uncacheable |

## Verification
Several checks can hit the same request, and the main risk is that they resolve in the wrong order. The bench builds requests where two of them coincide: a misaligned access that would also miss or be denied, a permission denial on an entry whose fault-on bit is also set, and a direct-window access by privileged code running in user mode. It also includes direct-window and physical addresses that land in the uncached or register region. A behavioural model judges each case every cycle, and the outcome must be the fault of the higher-priority check, with exactly the status bits that check defines.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ALIGN = 3'd1,
    FLT_PAGE  = 3'd2,
    FLT_ACV   = 3'd3,
    FLT_MISS  = 3'd4,
    FLT_DMISS = 3'd5,
    FLT_MCHK  = 3'd6,
    FLT_UNIMP = 3'd7
  } fault_e;

  typedef enum logic [1:0] {
    SRC_PHYS   = 2'd0,
    SRC_DIRECT = 2'd1,
    SRC_PAGE   = 2'd2
  } paSrc_e;

  typedef struct packed {
    paSrc_e src;
    logic   keepAddr;
    logic   markUncache;
  } dpStrobe_t;

  localparam int STATUS_W = 6;
  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_FONR  = 2;
  localparam int ST_FONW  = 3;
  localparam int ST_BADVA = 4;
  localparam int ST_MISS  = 5;

  localparam logic [1:0] MODE_KERNEL = 2'd0;

endpackage

// File: rtl/dtx_xlate_ctrl.sv
module dtx_xlate_ctrl
  import dtx_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_IMPL   = 48,
  parameter int DIRECT_HI = 47,
  parameter int DIRECT_LO = 41,
  parameter int DIRECT_TAG = 'h7E
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [VA_W-1:0]     reqVa,
  input  logic [1:0]          reqSizeLog2,
  input  logic                reqWrite,
  input  logic                reqPhys,
  input  logic                reqPriv,
  input  logic                reqAlt,
  input  logic                reqPteFetch,
  input  logic [1:0]          curMode,
  input  logic [1:0]          altMode,
  input  logic                tbHit,
  input  logic [3:0]          tbReadEn,
  input  logic [3:0]          tbWriteEn,
  input  logic                tbFaultOnRead,
  input  logic                tbFaultOnWrite,
  input  logic                paOutside,
  input  logic                paUncBit,
  input  logic                paRegSpace,
  output dpStrobe_t           strobe,
  output logic                rspValid,
  output logic [2:0]          rspFault,
  output logic [STATUS_W-1:0] rspStatus
);

  localparam int DIR_W = DIRECT_HI - DIRECT_LO + 1;

  logic [3:0]          sizeMask;
  logic                misaligned;
  logic [1:0]          effMode;
  logic                vaValid;
  logic                inDirect;
  logic                rdOk;
  logic                wrOk;
  fault_e              fault;
  logic [STATUS_W-1:0] status;
  paSrc_e              src;

  assign sizeMask   = (4'd1 << reqSizeLog2) - 4'd1;
  assign misaligned = |(reqVa[3:0] & sizeMask);
  assign effMode    = reqPriv ? (reqAlt ? altMode : MODE_KERNEL) : curMode;
  assign vaValid    = (&reqVa[VA_W-1:VA_IMPL-1]) | ~(|reqVa[VA_W-1:VA_IMPL-1]);
  assign inDirect   = reqVa[DIRECT_HI:DIRECT_LO] == DIR_W'(DIRECT_TAG);
  assign rdOk       = tbReadEn[effMode];
  assign wrOk       = tbWriteEn[effMode];

  always_comb begin
    fault  = FLT_NONE;
    status = '0;
    src    = SRC_PAGE;
    if (misaligned) begin
      fault          = FLT_ALIGN;
      status[ST_WR]  = reqWrite;
    end else begin
      if (reqPhys) begin
        src = SRC_PHYS;
      end else if (!vaValid) begin
        fault            = FLT_PAGE;
        status[ST_WR]    = reqWrite;
        status[ST_BADVA] = 1'b1;
        status[ST_ACV]   = 1'b1;
      end else if (inDirect) begin
        src = SRC_DIRECT;
        if (curMode != MODE_KERNEL) begin
          fault          = FLT_ACV;
          status[ST_WR]  = reqWrite;
          status[ST_ACV] = 1'b1;
        end
      end else if (!tbHit) begin
        fault           = reqPteFetch ? FLT_DMISS : FLT_MISS;
        status[ST_WR]   = reqWrite;
        status[ST_MISS] = 1'b1;
      end else if (reqWrite) begin
        if (!wrOk) begin
          fault           = FLT_PAGE;
          status[ST_WR]   = 1'b1;
          status[ST_ACV]  = 1'b1;
          status[ST_FONW] = tbFaultOnWrite;
        end else if (tbFaultOnWrite) begin
          fault           = FLT_PAGE;
          status[ST_WR]   = 1'b1;
          status[ST_FONW] = 1'b1;
        end
      end else begin
        if (!rdOk) begin
          fault           = FLT_ACV;
          status[ST_ACV]  = 1'b1;
          status[ST_FONR] = tbFaultOnRead;
        end else if (tbFaultOnRead) begin
          fault           = FLT_PAGE;
          status[ST_FONR] = 1'b1;
        end
      end
      if (fault == FLT_NONE) begin
        if (paOutside) begin
          fault = FLT_MCHK;
        end else if (paUncBit && paRegSpace) begin
          fault = FLT_UNIMP;
        end
      end
    end
  end

  always_comb begin
    strobe.src         = src;
    strobe.keepAddr    = reqValid && (fault == FLT_NONE);
    strobe.markUncache = reqValid && (fault == FLT_NONE) && paUncBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspFault  <= '0;
      rspStatus <= '0;
    end else begin
      rspValid  <= reqValid;
      rspFault  <= reqValid ? fault : FLT_NONE;
      rspStatus <= reqValid ? status : '0;
    end
  end

endmodule

// File: rtl/dtx_xlate_dp.sv
module dtx_xlate_dp
  import dtx_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PA_IMPL    = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int SEXT_BIT   = 40,
  parameter int UNC_BIT    = 43,
  parameter int UNC_CLR_HI = 42,
  parameter int UNC_CLR_LO = 35,
  parameter int REG_LO     = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [VA_W-1:0]          reqVa,
  input  logic [VA_W-PAGE_SHIFT-1:0] tbPpn,
  input  dpStrobe_t                strobe,
  output logic                     paOutside,
  output logic                     paUncBit,
  output logic                     paRegSpace,
  output logic [VA_W-1:0]          rspPaddr,
  output logic                     rspUncache
);

  localparam logic [VA_W-1:0] ONE       = VA_W'(1);
  localparam logic [VA_W-1:0] IMPL_MASK = (ONE << PA_IMPL) - ONE;
  localparam logic [VA_W-1:0] LOW_MASK  = (ONE << SEXT_BIT) - ONE;
  localparam logic [VA_W-1:0] HI_FILL   = IMPL_MASK & ~LOW_MASK;
  localparam logic [VA_W-1:0] CLR_MASK  =
    ((ONE << (UNC_CLR_HI + 1)) - ONE) & ~((ONE << UNC_CLR_LO) - ONE);

  logic [VA_W-1:0] directPa;
  logic [VA_W-1:0] pagePa;
  logic [VA_W-1:0] rawPa;
  logic [VA_W-1:0] finalPa;

  always_comb begin
    directPa = reqVa & IMPL_MASK;
    if (directPa[SEXT_BIT]) directPa = directPa | HI_FILL;
    else                    directPa = directPa & LOW_MASK;
  end

  assign pagePa = {tbPpn, reqVa[PAGE_SHIFT-1:0]};

  always_comb begin
    unique case (strobe.src)
      SRC_PHYS:   rawPa = reqVa;
      SRC_DIRECT: rawPa = directPa;
      default:    rawPa = pagePa;
    endcase
  end

  assign paOutside  = |(rawPa & ~IMPL_MASK);
  assign paUncBit   = rawPa[UNC_BIT];
  assign paRegSpace = &rawPa[UNC_BIT:REG_LO];
  assign finalPa    = strobe.markUncache ? (rawPa & ~CLR_MASK) : rawPa;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPaddr   <= '0;
      rspUncache <= 1'b0;
    end else begin
      rspPaddr   <= strobe.keepAddr ? finalPa : '0;
      rspUncache <= strobe.markUncache;
    end
  end

endmodule

// File: rtl/dtx_xlate_chk.sv
module dtx_xlate_chk
  import dtx_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int VA_IMPL    = 48,
  parameter int PA_IMPL    = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int DIRECT_HI  = 47,
  parameter int DIRECT_LO  = 41,
  parameter int DIRECT_TAG = 'h7E,
  parameter int SEXT_BIT   = 40,
  parameter int UNC_BIT    = 43,
  parameter int UNC_CLR_HI = 42,
  parameter int UNC_CLR_LO = 35,
  parameter int REG_LO     = 20,
  localparam int PPN_W     = VA_W - PAGE_SHIFT
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [VA_W-1:0]     reqVa,
  input  logic [1:0]          reqSizeLog2,
  input  logic                reqWrite,
  input  logic                reqPhys,
  input  logic                reqPriv,
  input  logic                reqAlt,
  input  logic                reqPteFetch,
  input  logic [1:0]          curMode,
  input  logic [1:0]          altMode,
  input  logic                tbHit,
  input  logic [PPN_W-1:0]    tbPpn,
  input  logic [3:0]          tbReadEn,
  input  logic [3:0]          tbWriteEn,
  input  logic                tbFaultOnRead,
  input  logic                tbFaultOnWrite,
  output logic                rspValid,
  output logic [2:0]          rspFault,
  output logic [STATUS_W-1:0] rspStatus,
  output logic [VA_W-1:0]     rspPaddr,
  output logic                rspUncache
);

  dpStrobe_t strobe;
  logic      paOutside;
  logic      paUncBit;
  logic      paRegSpace;

  dtx_xlate_ctrl #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .DIRECT_HI(DIRECT_HI),
    .DIRECT_LO(DIRECT_LO), .DIRECT_TAG(DIRECT_TAG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa),
    .reqSizeLog2(reqSizeLog2), .reqWrite(reqWrite), .reqPhys(reqPhys),
    .reqPriv(reqPriv), .reqAlt(reqAlt), .reqPteFetch(reqPteFetch),
    .curMode(curMode), .altMode(altMode), .tbHit(tbHit),
    .tbReadEn(tbReadEn), .tbWriteEn(tbWriteEn),
    .tbFaultOnRead(tbFaultOnRead), .tbFaultOnWrite(tbFaultOnWrite),
    .paOutside(paOutside), .paUncBit(paUncBit), .paRegSpace(paRegSpace),
    .strobe(strobe), .rspValid(rspValid), .rspFault(rspFault),
    .rspStatus(rspStatus)
  );

  dtx_xlate_dp #(
    .VA_W(VA_W), .PA_IMPL(PA_IMPL), .PAGE_SHIFT(PAGE_SHIFT),
    .SEXT_BIT(SEXT_BIT), .UNC_BIT(UNC_BIT), .UNC_CLR_HI(UNC_CLR_HI),
    .UNC_CLR_LO(UNC_CLR_LO), .REG_LO(REG_LO)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqVa(reqVa), .tbPpn(tbPpn), .strobe(strobe),
    .paOutside(paOutside), .paUncBit(paUncBit), .paRegSpace(paRegSpace),
    .rspPaddr(rspPaddr), .rspUncache(rspUncache)
  );

endmodule

// File: rtl/dtx_xlate_chk_sva.sv
module dtx_xlate_chk_sva #(
  parameter int VA_W    = 64,
  parameter int PA_IMPL = 44
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [VA_W-1:0] reqVa,
  input logic [1:0]      reqSizeLog2,
  input logic            reqPhys,
  input logic            rspValid,
  input logic [2:0]      rspFault,
  input logic [5:0]      rspStatus,
  input logic [VA_W-1:0] rspPaddr,
  input logic            rspUncache
);

  logic reqAligned;
  logic physClean;
  assign reqAligned = ~|(reqVa[3:0] & ((4'd1 << reqSizeLog2) - 4'd1));
  assign physClean  = ~|reqVa[VA_W-1:PA_IMPL-1];

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && rspFault == 3'd0 && rspPaddr == '0)); // R2
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault != 3'd0) |-> (rspPaddr == '0 && !rspUncache)); // R2
  AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqAligned) |=> (rspFault == 3'd1 && rspStatus[5:1] == '0)); // R3
  AST_PHYS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqPhys && reqAligned && physClean) |=>
      (rspFault == 3'd0 && rspPaddr == $past(reqVa))); // R5
  AST_MISS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault == 3'd4 || rspFault == 3'd5) |-> rspStatus[5]); // R9
  AST_MCHK_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault == 3'd6) |-> (rspStatus == '0)); // R13
  AST_UNCACHE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    rspUncache |-> (rspFault == 3'd0 && rspPaddr[43] && rspPaddr[42:35] == '0)); // R14

endmodule

bind dtx_xlate_chk dtx_xlate_chk_sva #(.VA_W(VA_W), .PA_IMPL(PA_IMPL)) u_sva (.*);

// File: tb/dtx_xlate_chk_bench.sv
`timescale 1ns/1ps
module dtx_xlate_chk_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] reqVa = '0;
  logic [1:0]  reqSizeLog2 = '0;
  logic        reqWrite = 1'b0, reqPhys = 1'b0, reqPriv = 1'b0, reqAlt = 1'b0;
  logic        reqPteFetch = 1'b0;
  logic [1:0]  curMode = '0, altMode = '0;
  logic        tbHit = 1'b0;
  logic [50:0] tbPpn = '0;
  logic [3:0]  tbReadEn = '0, tbWriteEn = '0;
  logic        tbFaultOnRead = 1'b0, tbFaultOnWrite = 1'b0;
  logic        rspValid;
  logic [2:0]  rspFault;
  logic [5:0]  rspStatus;
  logic [63:0] rspPaddr;
  logic        rspUncache;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dtx_xlate_chk u_dtx_xlate_chk (.*);

  typedef struct {
    logic        valid;
    logic [2:0]  fault;
    logic [5:0]  status;
    logic [63:0] pa;
    logic        unc;
    string       tag;
  } expect_t;

  function automatic expect_t model();
    expect_t e;
    logic [63:0] pa;
    logic [1:0]  mode;
    logic [5:0]  wr;
    logic [16:0] top;
    e.valid = reqValid; e.fault = 0; e.status = 0; e.pa = 0; e.unc = 0; e.tag = "R2";
    if (!reqValid) return e;
    wr = reqWrite ? 6'd1 : 6'd0;
    if ((reqVa % (64'd1 << reqSizeLog2)) != 0) begin
      e.fault = 1; e.status = wr; e.tag = "R3"; return e;
    end
    if (reqPriv) mode = reqAlt ? altMode : 2'd0;
    else mode = curMode;
    if (reqPhys) begin
      pa = reqVa; e.tag = "R5";
    end else begin
      top = reqVa[63:47];
      if (top != 17'h0 && top != 17'h1FFFF) begin
        e.fault = 2; e.status = wr | 6'h12; e.tag = "R6"; return e;
      end
      if (reqVa[47:41] == 7'h7E) begin
        if (curMode != 0) begin
          e.fault = 3; e.status = wr | 6'h02; e.tag = "R7"; return e;
        end
        pa = reqVa & 64'hFFF_FFFF_FFFF;
        if (pa[40]) pa = pa | 64'hF00_0000_0000;
        else pa = pa & 64'hFF_FFFF_FFFF;
        e.tag = "R8";
      end else if (!tbHit) begin
        e.fault = reqPteFetch ? 3'd5 : 3'd4; e.status = wr | 6'h20; e.tag = "R9";
        return e;
      end else begin
        pa = (64'(tbPpn) << 13) + (reqVa & 64'h1FFF);
        e.tag = reqPriv ? "R4" : "R10";
        if (reqWrite) begin
          if (!tbWriteEn[mode]) begin
            e.fault = 2; e.status = 6'h03 | (tbFaultOnWrite ? 6'h08 : 6'h0);
            e.tag = reqPriv ? "R4" : "R11"; return e;
          end
          if (tbFaultOnWrite) begin
            e.fault = 2; e.status = 6'h09; e.tag = "R11"; return e;
          end
        end else begin
          if (!tbReadEn[mode]) begin
            e.fault = 3; e.status = 6'h02 | (tbFaultOnRead ? 6'h04 : 6'h0);
            e.tag = reqPriv ? "R4" : "R12"; return e;
          end
          if (tbFaultOnRead) begin
            e.fault = 2; e.status = 6'h04; e.tag = "R12"; return e;
          end
        end
      end
    end
    if ((pa >> 44) != 0) begin
      e.fault = 6; e.tag = "R13"; return e;
    end
    if (pa[43]) begin
      if (pa[43:20] == 24'hFFFFFF) begin
        e.fault = 7; e.tag = "R14"; return e;
      end
      e.unc = 1; pa = pa & ~64'h7F8_0000_0000; e.tag = "R14";
    end
    e.pa = pa;
    return e;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    expect_t e;
    e = model();
    @(negedge clk);
    check(e.tag, 64'(rspValid), 64'(e.valid), "valid");
    check(e.tag, 64'(rspFault), 64'(e.fault), "fault");
    check(e.tag, 64'(rspStatus), 64'(e.status), "status");
    check(e.tag, rspPaddr, e.pa, "paddr");
    check(e.tag, 64'(rspUncache), 64'(e.unc), "uncache");
  endtask

  task automatic setReq(input logic [63:0] va, input logic [1:0] sz, input logic wrt,
                        input logic phys, input logic priv, input logic alt,
                        input logic pte, input logic [1:0] cm, input logic [1:0] am,
                        input logic hit, input logic [50:0] ppn, input logic [3:0] ren,
                        input logic [3:0] wen, input logic fonr, input logic fonw);
    reqValid = 1; reqVa = va; reqSizeLog2 = sz; reqWrite = wrt; reqPhys = phys;
    reqPriv = priv; reqAlt = alt; reqPteFetch = pte; curMode = cm; altMode = am;
    tbHit = hit; tbPpn = ppn; tbReadEn = ren; tbWriteEn = wen;
    tbFaultOnRead = fonr; tbFaultOnWrite = fonw;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 64'(rspValid), 0, "valid in reset");
    check("R1", rspPaddr, 0, "paddr in reset");
    rstN = 1;
    @(negedge clk);
    check("R1", 64'(rspFault), 0, "fault after reset");
    check("R1", 64'(rspStatus), 0, "status after reset");
    // R10 plain hit
    setReq(64'h0000_0000_1234_5678, 3, 0, 0, 0, 0, 0, 0, 0, 1, 51'h1ABC, 4'hF, 4'hF, 0, 0);
    // R3 misaligned store that would also miss
    setReq(64'h0000_0000_0000_1002, 2, 1, 0, 0, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0);
    setReq(64'h0000_0000_0000_1001, 1, 0, 1, 0, 0, 0, 0, 0, 1, 0, 4'hF, 4'hF, 0, 0);
    // R9 normal and double miss
    setReq(64'h0000_0000_0040_0000, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    setReq(64'h0000_0000_0040_0000, 3, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R11 store denied with fonw, permitted with fonw
    setReq(64'h0000_0000_0000_2000, 2, 1, 0, 0, 0, 0, 3, 0, 1, 51'h10, 4'hF, 4'h7, 0, 1);
    setReq(64'h0000_0000_0000_2000, 2, 1, 0, 0, 0, 0, 3, 0, 1, 51'h10, 4'hF, 4'hF, 0, 1);
    // R12 load denied with fonr, permitted with fonr
    setReq(64'h0000_0000_0000_3000, 0, 0, 0, 0, 0, 0, 3, 0, 1, 51'h10, 4'h7, 4'hF, 1, 0);
    setReq(64'h0000_0000_0000_3000, 0, 0, 0, 0, 0, 0, 3, 0, 1, 51'h10, 4'hF, 4'hF, 1, 0);
    // R4 privileged alt and kernel override
    setReq(64'h0000_0000_0000_4000, 3, 0, 0, 1, 1, 0, 3, 2, 1, 51'h22, 4'b0100, 0, 0, 0);
    setReq(64'h0000_0000_0000_4000, 3, 0, 0, 1, 0, 0, 3, 2, 1, 51'h22, 4'b0001, 0, 0, 0);
    setReq(64'h0000_0000_0000_4000, 3, 1, 0, 1, 1, 0, 0, 3, 1, 51'h22, 0, 4'b0111, 0, 0);
    // R8 direct window, R7 user access, privileged user access
    setReq(64'hFFFF_FC00_0000_1000, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    setReq(64'hFFFF_FD00_0000_2000, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    setReq(64'hFFFF_FC00_0000_1000, 3, 1, 0, 0, 0, 0, 3, 0, 1, 0, 4'hF, 4'hF, 0, 0);
    setReq(64'hFFFF_FC00_0000_1000, 3, 0, 0, 1, 0, 0, 3, 0, 1, 0, 4'hF, 4'hF, 0, 0);
    // R6 invalid address
    setReq(64'h0001_0000_0000_0000, 3, 1, 0, 0, 0, 0, 0, 0, 1, 0, 4'hF, 4'hF, 0, 0);
    // R5 physical, R13 machine check, R14 register space and uncached
    setReq(64'h0000_0000_00AB_CDE0, 3, 0, 1, 0, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0);
    setReq(64'h0010_0000_0000_0000, 3, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    setReq(64'h0000_0FFF_FFF0_0000, 3, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    setReq(64'h0000_08AB_CDEF_0000, 3, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    setReq(64'h0000_0000_0000_0040, 3, 0, 0, 0, 0, 0, 0, 0, 1, 51'h4_0000_0000, 4'hF, 4'hF, 0, 0);
    // R2 idle cycle
    reqValid = 0;
    step();
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] va;
      int k;
      k = $urandom % 6;
      va = {$urandom, $urandom};
      case (k)
        0: va = va & 64'h0000_7FFF_FFFF_FFFF;
        1: va = {16'hFFFF, 7'h7E, va[40:0]};
        2: va = va;
        3: va = va & 64'h0000_0FFF_FFFF_FFFF;
        4: va = {40'hFF_FFFF_FFFF, va[23:0]};
        default: va = va & 64'h0000_0000_00FF_FFF8;
      endcase
      reqValid = ($urandom % 8) != 0;
      reqVa = va; reqSizeLog2 = 2'($urandom); reqWrite = 1'($urandom);
      reqPhys = ($urandom % 5) == 0; reqPriv = 1'($urandom); reqAlt = 1'($urandom);
      reqPteFetch = 1'($urandom); curMode = 2'($urandom); altMode = 2'($urandom);
      tbHit = ($urandom % 4) != 0;
      tbPpn = ($urandom % 8 == 0) ? 51'({$urandom, $urandom}) : 51'($urandom % 32'h80_0000);
      tbReadEn = 4'($urandom); tbWriteEn = 4'($urandom);
      tbFaultOnRead = ($urandom % 4) == 0; tbFaultOnWrite = ($urandom % 4) == 0;
      step();
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule